// File: doc/BRIEF.md
# Polarity-Configurable Serial Transmit Channel

This block is the transmit half of a processor serial port. Software writes one parallel word into a holding register. When a frame start is seen, the word moves into a shift register and leaves on a single data pin, least-significant bit first, one bit per active edge of an externally supplied bit clock. The bit clock and the frame-sync line both come from outside the chip. Each is brought into the system clock domain by a synchronizer and turned into a one-cycle edge pulse. A control input chooses which edge of each line counts as active.

The data pin is described as two pad-control signals: a data level and a drive enable. A mode input chooses a three-state driver or an open-drain driver. In open-drain mode a one releases the pin and a zero pulls it low. An active-low enable input can release the pin at any time, and shifting goes on underneath while it does. A buffer-empty flag tells software when the holding register can take the next word.

Top module: `polser_tx`

## Requirements
- R1: The bits of a word appear on the pin in order bit 0 first, bit WIDTH-1 last.
- R2: After an active bit-clock transition at the input, the pin takes its new bit at the third system-clock edge: two synchronizer stages, then the edge-detect stage. The pin holds that bit until the next active bit-clock edge.
- R3: An active frame-sync edge with a word held moves the word into the shifter and raises buf_empty. The first bit is driven on the next active bit-clock edge after that, never on an edge that arrives in the same cycle as the frame start.
- R4: inv_bclk=1 makes a falling edge of bclk_in the active bit-clock edge. inv_fsync=1 makes a falling edge of fsync_in the active frame-sync edge.
- R5: With od_mode=0, a driven bit gives pad_oe=1 and pad_do equal to the bit. With od_mode=1, a 0 bit gives pad_oe=1 and pad_do=0, a 1 bit gives pad_oe=0, and pad_do is always 0.
- R6: After reset, pad_oe=0 and buf_empty=1.
- R7: While oe_n=1, pad_oe is 0 in the same cycle. Shifting goes on, and later bits are unaffected.
- R8: A write sets buf_empty to 0 on the next cycle. A second write before a frame start replaces the held word.
- R9: A frame sync is ignored when the holding buffer is empty or while a word is armed or shifting. Nothing is sent, and a held word stays held.
- R10: A write in the same cycle as a frame-start transfer keeps the new word. The old word is the one shifted, and buf_empty stays 0.
- R11: One active bit-clock edge after the last bit, the pin is released (pad_oe=0, pad_do=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | WIDTH | Word to transmit |
| inv_bclk | input | 1 | 1: falling edge of bclk_in is active |
| inv_fsync | input | 1 | 1: falling edge of fsync_in is active |
| od_mode | input | 1 | 1: open-drain, 0: three-state |
| bclk_in | input | 1 | External bit clock, asynchronous |
| fsync_in | input | 1 | External frame sync, asynchronous |
| oe_n | input | 1 | Active-low output enable |
| buf_empty | output | 1 | High while the holding buffer is empty |
| pad_do | output | 1 | Level driven onto the pin |
| pad_oe | output | 1 | Pin drive enable |

## Verification
Two pairs of events can land in the same system-clock cycle. The first pair is a processor write and the frame-start transfer out of the holding buffer. The second pair is a frame-sync edge and a bit-clock edge. The bench provokes the first by placing the write strobe exactly in the cycle the synchronized frame edge acts. It judges the result by the word that comes out, by the word sent in the following frame, and by buf_empty staying low. It provokes the second by making both external lines active on the same negative edge. It then checks that the pin stays released until a later bit-clock edge, and that the full word still comes out intact. A behavioural model runs alongside and compares all three outputs on every clock.

// File: rtl/polser_pkg.sv
// Shared types for the serial transmit channel.
// Assumes: included first in compile order.
package polser_pkg;

    // Shifter phases: waiting for a frame, waiting for the first bit edge, sending bits.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2
    } tx_state_e;

endpackage

// File: rtl/polser_edge.sv
// Brings one asynchronous line into the system clock domain, applies the
// polarity selection and emits a one-cycle pulse on the active edge.
// Assumes: the line is slower than the system clock by at least 2x.
// No pulse is emitted in the first cycle after reset.
module polser_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic invert,
    output logic rise
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level;
    logic                   prev_q;
    logic                   primed_q;

    // First synchronizer stage samples the raw line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= raw;
    end

    // Remaining synchronizer stages, one flop each.
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= sync_q[i-1];
        end
    end

    assign level = sync_q[LAST] ^ invert;

    // Keep the previous internal level and note that one cycle has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= level;
            primed_q <= 1'b1;
        end
    end

    assign rise = primed_q & level & ~prev_q;

endmodule

// File: rtl/polser_holdbuf.sv
// Single-word holding register between processor writes and the shifter.
// Assumes: a write and a take in the same cycle keeps the written word.
module polser_holdbuf #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             take,
    output logic [WIDTH-1:0] word,
    output logic             empty
);
    logic full_q;

    // Capture on write, mark empty when the shifter takes the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            word   <= '0;
        end else if (wr_en) begin
            full_q <= 1'b1;
            word   <= wr_data;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    assign empty = ~full_q;

endmodule

// File: rtl/polser_shifter.sv
// Frame-start handling and LSB-first serializer.
// Assumes: start and tick are one-cycle pulses. A start in IDLE with a word
// held loads the shifter. The first bit goes out on the next tick after that.
module polser_shifter
    import polser_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic             have_word,
    input  logic [WIDTH-1:0] word,
    output logic             take,
    output logic             dout,
    output logic             driving
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(WIDTH - 1);

    tx_state_e        state_q;
    logic [WIDTH-1:0] sh_q;
    logic [CW-1:0]    cnt_q;

    assign take    = (state_q == ST_IDLE) && start && have_word;
    assign driving = (state_q == ST_SHIFT);

    // Phase sequencing, bit output and shift on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sh_q    <= '0;
            cnt_q   <= '0;
            dout    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        sh_q    <= word;
                        state_q <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (tick) begin
                        dout    <= sh_q[0];
                        sh_q    <= sh_q >> 1;
                        cnt_q   <= LAST_CNT;
                        state_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (cnt_q == '0) begin
                            dout    <= 1'b0;
                            state_q <= ST_IDLE;
                        end else begin
                            dout  <= sh_q[0];
                            sh_q  <= sh_q >> 1;
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/polser_padctl.sv
// Maps the serial bit onto pad data and pad enable for the chosen driver type.
// Assumes: purely combinational. oe_n releases the pin in the same cycle.
module polser_padctl (
    input  logic driving,
    input  logic dout,
    input  logic od_mode,
    input  logic oe_n,
    output logic pad_do,
    output logic pad_oe
);
    // Select open-drain or three-state pad behaviour.
    always_comb begin
        pad_do = 1'b0;
        pad_oe = 1'b0;
        if (driving && !oe_n) begin
            if (od_mode) begin
                pad_oe = ~dout;
            end else begin
                pad_oe = 1'b1;
                pad_do = dout;
            end
        end
    end

endmodule

// File: rtl/polser_tx.sv
// Top of the serial transmit channel: holding buffer, two edge detectors,
// serializer and pad control.
// Assumes: bclk_in and fsync_in are asynchronous and slower than clk/2.
module polser_tx #(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             inv_bclk,
    input  logic             inv_fsync,
    input  logic             od_mode,
    input  logic             bclk_in,
    input  logic             fsync_in,
    input  logic             oe_n,
    output logic             buf_empty,
    output logic             pad_do,
    output logic             pad_oe
);
    logic             bc_rise;
    logic             fs_rise;
    logic             take;
    logic             driving;
    logic             dout_bit;
    logic [WIDTH-1:0] held_word;

    polser_edge #(.SYNC_STAGES(SYNC_STAGES)) u_bclk_edge (
        .clk(clk), .rst_n(rst_n), .raw(bclk_in), .invert(inv_bclk), .rise(bc_rise)
    );

    polser_edge #(.SYNC_STAGES(SYNC_STAGES)) u_fsync_edge (
        .clk(clk), .rst_n(rst_n), .raw(fsync_in), .invert(inv_fsync), .rise(fs_rise)
    );

    polser_holdbuf #(.WIDTH(WIDTH)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .take(take), .word(held_word), .empty(buf_empty)
    );

    polser_shifter #(.WIDTH(WIDTH)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(fs_rise), .tick(bc_rise),
        .have_word(~buf_empty), .word(held_word), .take(take),
        .dout(dout_bit), .driving(driving)
    );

    polser_padctl u_pad (
        .driving(driving), .dout(dout_bit), .od_mode(od_mode), .oe_n(oe_n),
        .pad_do(pad_do), .pad_oe(pad_oe)
    );

endmodule

// File: rtl/polser_tx_chk.sv
// Property checker for polser_tx. It is attached by the bind statement at the end of this file.
// Assumes: it observes the edge pulse, the transfer strobe and the serializer state through the bind.
module polser_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic oe_n,
    input logic od_mode,
    input logic pad_do,
    input logic pad_oe,
    input logic buf_empty,
    input logic bc_rise,
    input logic take,
    input logic driving,
    input logic dout_bit
);
    p_hiz_when_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !pad_oe);

    p_od_never_drives_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        od_mode |-> !pad_do);

    p_write_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !buf_empty);

    p_transfer_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_en) |=> buf_empty);

    p_bit_held_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bc_rise) |-> $stable(dout_bit));

    p_idle_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !driving |-> (!pad_oe && !pad_do));

    p_take_needs_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !buf_empty);

endmodule

bind polser_tx polser_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .oe_n(oe_n), .od_mode(od_mode),
    .pad_do(pad_do), .pad_oe(pad_oe), .buf_empty(buf_empty), .bc_rise(bc_rise),
    .take(take), .driving(driving), .dout_bit(dout_bit)
);

// File: tb/polser_tx_bench.sv
`timescale 1ns/1ps
module polser_tx_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         inv_bclk = 1'b0;
    logic         inv_fsync = 1'b0;
    logic         od_mode = 1'b0;
    logic         bclk_in = 1'b0;
    logic         fsync_in = 1'b0;
    logic         oe_n = 1'b0;
    logic         buf_empty, pad_do, pad_oe;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R6";

    always #2.5 clk = ~clk;

    polser_tx #(.WIDTH(W)) u_polser_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .inv_bclk(inv_bclk), .inv_fsync(inv_fsync), .od_mode(od_mode),
        .bclk_in(bclk_in), .fsync_in(fsync_in), .oe_n(oe_n),
        .buf_empty(buf_empty), .pad_do(pad_do), .pad_oe(pad_oe)
    );

    // Behavioural reference: input histories, a held word and a queue of pending bits.
    bit     hb[$];
    bit     hf[$];
    bit     lb_prev, lf_prev;
    int     edges_since_reset;
    bit     m_full;
    bit [W-1:0] m_buf;
    bit     m_pending[$];
    int     m_phase;       // 0 idle, 1 waiting for first bit, 2 sending
    bit     m_bit;

    always @(posedge clk) begin
        if (!rst_n) begin
            hb = '{0, 0}; hf = '{0, 0};
            lb_prev = 0; lf_prev = 0; edges_since_reset = 0;
            m_full = 0; m_buf = '0; m_pending.delete(); m_phase = 0; m_bit = 0;
        end else begin
            bit lb, lf, br, fr, took;
            lb = hb[1] ^ inv_bclk;
            lf = hf[1] ^ inv_fsync;
            br = (edges_since_reset > 0) && lb && !lb_prev;
            fr = (edges_since_reset > 0) && lf && !lf_prev;
            took = 0;
            if (m_phase == 0) begin
                if (fr && m_full) begin
                    m_pending.delete();
                    for (int i = 0; i < W; i++) m_pending.push_back(m_buf[i]);
                    m_phase = 1; took = 1;
                end
            end else if (br) begin
                if (m_pending.size() == 0) begin
                    m_phase = 0; m_bit = 0;
                end else begin
                    m_bit = m_pending.pop_front();
                    m_phase = 2;
                end
            end
            if (wr_en) begin m_buf = wr_data; m_full = 1; end
            else if (took) m_full = 0;
            hb.push_front(bclk_in); void'(hb.pop_back());
            hf.push_front(fsync_in); void'(hf.pop_back());
            lb_prev = lb; lf_prev = lf;
            edges_since_reset++;
        end
    end

    // Every-cycle comparison of all outputs against the reference.
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            bit drv, e_oe, e_do;
            drv  = (m_phase == 2) && !oe_n;
            e_oe = drv && (od_mode ? !m_bit : 1'b1);
            e_do = drv && !od_mode && m_bit;
            n_checks++;
            if (pad_oe !== e_oe || pad_do !== e_do || buf_empty !== !m_full) begin
                n_fail++;
                $display("FAIL %s cycle-compare: oe/do/empty act=%b%b%b exp=%b%b%b",
                         cur_req, pad_oe, pad_do, buf_empty, e_oe, e_do, !m_full);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_word(input logic [W-1:0] d);
        wr_en = 1'b1; wr_data = d;
        wait_n(1);
        wr_en = 1'b0;
    endtask

    task automatic fs_pulse();
        fsync_in = ~inv_fsync; wait_n(4);
        fsync_in = inv_fsync;  wait_n(4);
    endtask

    task automatic bit_pulse(output logic b, output logic oe);
        bclk_in = ~inv_bclk; wait_n(4);
        oe = pad_oe;
        b  = od_mode ? ~pad_oe : pad_do;
        bclk_in = inv_bclk;  wait_n(4);
    endtask

    task automatic shift_out(output logic [W-1:0] word);
        logic b, oe;
        word = '0;
        for (int i = 0; i < W; i++) begin
            bit_pulse(b, oe);
            word[i] = b;
        end
    endtask

    task automatic run_word(input logic [W-1:0] exp);
        logic [W-1:0] got;
        logic b, oe;
        fs_pulse();
        chk("R3 buffer empty after frame start", buf_empty, 1);
        shift_out(got);
        chk("R1 word LSB first", got, exp);
        bit_pulse(b, oe);
        chk("R11 released after last bit", oe, 0);
    endtask

    initial begin
        logic [W-1:0] got;
        logic b, oe;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        chk("R6 buf_empty after reset", buf_empty, 1);
        chk("R6 pad_oe after reset", pad_oe, 0);

        // R8: write clears empty; R1, R2, R3, R11 three-state word
        cur_req = "R8";
        write_word(16'hA5C3);
        chk("R8 write clears empty", buf_empty, 0);
        cur_req = "R1";
        run_word(16'hA5C3);

        // R7: output enable released during bits 4..7
        cur_req = "R7";
        write_word(16'h3C96);
        fs_pulse();
        for (int i = 0; i < W; i++) begin
            oe_n = (i >= 4 && i <= 7);
            bit_pulse(b, oe);
            if (oe_n) chk("R7 pin released while oe_n high", oe, 0);
            else      chk("R7 bit unaffected", b, (16'h3C96 >> i) & 1);
        end
        oe_n = 1'b0;
        bit_pulse(b, oe);

        // R9: frame sync with empty buffer sends nothing
        cur_req = "R9";
        fs_pulse();
        bit_pulse(b, oe);
        chk("R9 no drive after empty frame", oe, 0);
        chk("R9 still empty", buf_empty, 1);

        // R9: frame sync mid-word ignored, next word kept
        write_word(16'h0F1E);
        fs_pulse();
        for (int i = 0; i < 5; i++) bit_pulse(b, oe);
        write_word(16'hBEEF);
        fs_pulse();
        chk("R9 held word kept during shift", buf_empty, 0);
        for (int i = 0; i < W - 5; i++) bit_pulse(b, oe);
        bit_pulse(b, oe);
        chk("R9 released after word", oe, 0);
        chk("R9 word still held", buf_empty, 0);
        run_word(16'hBEEF);

        // R10: write lands in the transfer cycle
        cur_req = "R10";
        write_word(16'h1234);
        fsync_in = ~inv_fsync;
        wait_n(2);
        wr_en = 1'b1; wr_data = 16'h5678;
        wait_n(1);
        wr_en = 1'b0;
        wait_n(1);
        fsync_in = inv_fsync;
        wait_n(4);
        chk("R10 new word held", buf_empty, 0);
        shift_out(got);
        chk("R10 old word shifted", got, 16'h1234);
        bit_pulse(b, oe);
        run_word(16'h5678);

        // R3: frame sync and bit clock edge coincide
        cur_req = "R3";
        write_word(16'h8001);
        fsync_in = ~inv_fsync; bclk_in = ~inv_bclk;
        wait_n(4);
        chk("R3 no bit on coincident edge", pad_oe, 0);
        fsync_in = inv_fsync; bclk_in = inv_bclk;
        wait_n(4);
        shift_out(got);
        chk("R3 word after coincident edge", got, 16'h8001);
        bit_pulse(b, oe);

        // R4, R5: inverted polarities, open-drain pad
        cur_req = "R4";
        inv_bclk = 1'b1; bclk_in = 1'b1;
        inv_fsync = 1'b1; fsync_in = 1'b1;
        od_mode = 1'b1;
        wait_n(4);
        write_word(16'h1E7B);
        run_word(16'h1E7B);

        // R8: overwrite before frame start, open-drain
        cur_req = "R8";
        write_word(16'h0001);
        write_word(16'hC0DE);
        run_word(16'hC0DE);

        // R5: three-state again with inverted clocks
        cur_req = "R5";
        od_mode = 1'b0;
        write_word(16'h7FFE);
        run_word(16'h7FFE);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule